// File: doc/BRIEF.md
# Serial EEPROM Write-Command Slave

This block is the bus-facing receiver of a 128K-byte serial memory. It watches a two-wire serial bus (SCL, SDA), finds START and STOP conditions, and takes in a write command. The command is a device-select byte, two address bytes and one or more data bytes. Every accepted byte is acknowledged by holding SDA low for the ninth clock. Each data byte goes to a page buffer as a one-cycle strobe that carries the byte and its full 17-bit target address.

Address bit 16 travels inside the device-select byte. The two bytes that follow carry bits 15..8 and then bits 7..0. Further data bytes step through one 128-byte page and wrap at the page end. A STOP after at least one data byte raises a commit pulse and starts a fixed-length write cycle. For the whole of that cycle the receiver ignores the bus, its own select byte included.

Both bus lines pass through a multi-stage synchronizer clocked by a system clock that runs far faster than SCL. SDA is driven open-drain: the block only reports when the pin should be pulled low.

Top module: `i2c_eewr_slave`

## Requirements
- R1: After reset, sda_oe_o and busy_o are low and neither wr_stb_o nor commit_o pulses.
- R2: A device-select byte with bits 7..4 equal to 1010 and bit 0 equal to 0 (write) is acknowledged. Bits 3..2 are don't-care, and bit 1 is stored as address bit 16.
- R3: A device-select byte whose bits 7..4 differ from 1010, or whose bit 0 is 1, gets no ACK. No byte is acknowledged after it until the next START.
- R4: The two bytes after an accepted device-select byte are acknowledged and form address bits 15..8 (first) and 7..0 (second).
- R5: Every data byte is acknowledged and produces exactly one wr_stb_o pulse, with wr_data_o equal to the byte and wr_addr_o equal to its 17-bit target address.
- R6: Each further data byte targets the next address within the same 128-byte page. Bits 6..0 wrap from 127 to 0 and bits 16..7 never change, so the 129th byte of a transaction reuses the first byte's address.
- R7: A STOP after one or more data bytes gives one commit_o pulse. busy_o then stays high for exactly WR_CYCLES system clocks.
- R8: A STOP before any data byte produces no commit_o pulse and leaves busy_o low.
- R9: While busy_o is high, no byte is acknowledged and no wr_stb_o or commit_o pulse occurs, even for a valid write select byte.
- R10: A repeated START inside a transaction abandons it without a commit and restarts reception at the device-select byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_oe_o | output | 1 | High to pull SDA low (acknowledge) |
| wr_stb_o | output | 1 | One-cycle strobe per received data byte |
| wr_addr_o | output | 17 | Target address of the strobed byte |
| wr_data_o | output | 8 | Strobed data byte |
| commit_o | output | 1 | One-cycle pulse asking the page buffer to commit |
| busy_o | output | 1 | High while the write cycle runs |

## Verification
The hardest situation to reach is the page wrap: it needs more than 128 data bytes in one transaction, starting near the end of a page. The bench drives a directed burst of 130 bytes starting at in-page offset 126 and compares every strobed address with the wrapped expectation. The busy window is reached by issuing a new select byte right after a STOP. Random transactions with random addresses, lengths and data cover the common path.

// File: rtl/eewr_pkg.sv
package eewr_pkg;

    localparam int ADDR_W    = 17;
    localparam int BYTE_W    = 8;
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEV,
        PH_AHI,
        PH_ALO,
        PH_DATA
    } phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        logic dev_ok;
        logic ahi_ok;
        logic alo_ok;
        logic data_ok;
        logic commit;
    } rx_evt_t;

    function automatic logic select_is_write(input logic [BYTE_W-1:0] b);
        return (b[7:4] == DEV_TYPE) && (b[0] == 1'b0);
    endfunction

    function automatic logic [ADDR_W-1:0] page_step(input logic [ADDR_W-1:0] a,
                                                    input int unsigned pw);
        logic [ADDR_W-1:0] mask;
        mask = (ADDR_W'(1) << pw) - ADDR_W'(1);
        return (a & ~mask) | ((a + ADDR_W'(1)) & mask);
    endfunction

endpackage

// File: rtl/eewr_line_sync.sv
module eewr_line_sync
    import eewr_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;
    logic              scl_now;
    logic              sda_now;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) begin
                        scl_pipe[0] <= 1'b1;
                        sda_pipe[0] <= 1'b1;
                    end else begin
                        scl_pipe[0] <= scl_i;
                        sda_pipe[0] <= sda_i;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) begin
                        scl_pipe[g] <= 1'b1;
                        sda_pipe[g] <= 1'b1;
                    end else begin
                        scl_pipe[g] <= scl_pipe[g-1];
                        sda_pipe[g] <= sda_pipe[g-1];
                    end
                end
            end
        end
    endgenerate

    assign scl_now = scl_pipe[STAGES-1];
    assign sda_now = sda_pipe[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_now;
            sda_d <= sda_now;
        end
    end

    always_comb begin
        ev_o.start    = scl_now & scl_d & sda_d & ~sda_now;
        ev_o.stop     = scl_now & scl_d & ~sda_d & sda_now;
        ev_o.scl_rise = scl_now & ~scl_d;
        ev_o.scl_fall = ~scl_now & scl_d;
        ev_o.sda      = sda_now;
    end

endmodule

// File: rtl/eewr_rx_fsm.sv
module eewr_rx_fsm
    import eewr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev_i,
    input  logic              busy_i,
    output logic              sda_oe_o,
    output rx_evt_t           evt_o,
    output logic [BYTE_W-1:0] byte_o
);

    localparam int CNT_W = $clog2(BYTE_W + 1);

    phase_e            phase_q;
    logic [CNT_W-1:0]  bitcnt_q;
    logic [BYTE_W-1:0] shreg_q;
    logic              in_ack_q;
    logic              got_data_q;
    logic              oe_q;
    rx_evt_t           evt_q;

    always_ff @(posedge clk) begin
        evt_q <= '0;
        if (rst) begin
            phase_q    <= PH_IDLE;
            bitcnt_q   <= '0;
            shreg_q    <= '0;
            in_ack_q   <= 1'b0;
            got_data_q <= 1'b0;
            oe_q       <= 1'b0;
        end else if (busy_i) begin
            phase_q    <= PH_IDLE;
            in_ack_q   <= 1'b0;
            got_data_q <= 1'b0;
            oe_q       <= 1'b0;
        end else if (ev_i.start) begin
            phase_q    <= PH_DEV;
            bitcnt_q   <= '0;
            in_ack_q   <= 1'b0;
            got_data_q <= 1'b0;
            oe_q       <= 1'b0;
        end else if (ev_i.stop) begin
            if (phase_q == PH_DATA && got_data_q) begin
                evt_q.commit <= 1'b1;
            end
            phase_q    <= PH_IDLE;
            in_ack_q   <= 1'b0;
            got_data_q <= 1'b0;
            oe_q       <= 1'b0;
        end else if (phase_q != PH_IDLE) begin
            if (in_ack_q) begin
                if (ev_i.scl_fall) begin
                    oe_q     <= 1'b0;
                    in_ack_q <= 1'b0;
                    bitcnt_q <= '0;
                end
            end else begin
                if (ev_i.scl_rise && bitcnt_q < CNT_W'(BYTE_W)) begin
                    shreg_q  <= {shreg_q[BYTE_W-2:0], ev_i.sda};
                    bitcnt_q <= bitcnt_q + CNT_W'(1);
                end
                if (ev_i.scl_fall && bitcnt_q == CNT_W'(BYTE_W)) begin
                    unique case (phase_q)
                        PH_DEV: begin
                            if (select_is_write(shreg_q)) begin
                                evt_q.dev_ok <= 1'b1;
                                oe_q         <= 1'b1;
                                in_ack_q     <= 1'b1;
                                phase_q      <= PH_AHI;
                            end else begin
                                phase_q      <= PH_IDLE;
                            end
                        end
                        PH_AHI: begin
                            evt_q.ahi_ok <= 1'b1;
                            oe_q         <= 1'b1;
                            in_ack_q     <= 1'b1;
                            phase_q      <= PH_ALO;
                        end
                        PH_ALO: begin
                            evt_q.alo_ok <= 1'b1;
                            oe_q         <= 1'b1;
                            in_ack_q     <= 1'b1;
                            phase_q      <= PH_DATA;
                        end
                        PH_DATA: begin
                            evt_q.data_ok <= 1'b1;
                            oe_q          <= 1'b1;
                            in_ack_q      <= 1'b1;
                            got_data_q    <= 1'b1;
                        end
                        default: phase_q <= PH_IDLE;
                    endcase
                end
            end
        end
    end

    assign sda_oe_o = oe_q;
    assign evt_o    = evt_q;
    assign byte_o   = shreg_q;

endmodule

// File: rtl/eewr_addr_ctr.sv
module eewr_addr_ctr
    import eewr_pkg::*;
#(
    parameter int PAGE_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  rx_evt_t           evt_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (evt_i.dev_ok) begin
            addr_q[ADDR_W-1] <= byte_i[1];
        end else if (evt_i.ahi_ok) begin
            addr_q[15:8] <= byte_i;
        end else if (evt_i.alo_ok) begin
            addr_q[7:0] <= byte_i;
        end else if (evt_i.data_ok) begin
            addr_q <= page_step(addr_q, PAGE_W);
        end
    end

    assign addr_o = addr_q;

endmodule

// File: rtl/eewr_busy_timer.sv
module eewr_busy_timer #(
    parameter int WR_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic busy_o
);

    localparam int CW = $clog2(WR_CYCLES + 1);

    logic [CW-1:0] left_q;
    logic          busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
            busy_q <= 1'b0;
        end else if (start_i && !busy_q) begin
            left_q <= CW'(WR_CYCLES - 1);
            busy_q <= 1'b1;
        end else if (busy_q) begin
            if (left_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                left_q <= left_q - CW'(1);
            end
        end
    end

    assign busy_o = busy_q;

endmodule

// File: rtl/i2c_eewr_slave.sv
module i2c_eewr_slave
    import eewr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PAGE_W      = 7,
    parameter int WR_CYCLES   = 2000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe_o,
    output logic        wr_stb_o,
    output logic [16:0] wr_addr_o,
    output logic [7:0]  wr_data_o,
    output logic        commit_o,
    output logic        busy_o
);

    bus_ev_t           ev;
    rx_evt_t           evt;
    logic [BYTE_W-1:0] rx_byte;
    logic [ADDR_W-1:0] cur_addr;
    logic              busy;

    eewr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    eewr_rx_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ev_i     (ev),
        .busy_i   (busy),
        .sda_oe_o (sda_oe_o),
        .evt_o    (evt),
        .byte_o   (rx_byte)
    );

    eewr_addr_ctr #(.PAGE_W(PAGE_W)) u_addr (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (evt),
        .byte_i (rx_byte),
        .addr_o (cur_addr)
    );

    eewr_busy_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start_i (evt.commit),
        .busy_o  (busy)
    );

    assign wr_stb_o  = evt.data_ok;
    assign wr_addr_o = cur_addr;
    assign wr_data_o = rx_byte;
    assign commit_o  = evt.commit;
    assign busy_o    = busy;

endmodule

// File: rtl/eewr_checker.sv
module eewr_checker #(
    parameter int WR_CYCLES = 2000
) (
    input logic clk,
    input logic rst,
    input logic scl_i,
    input logic sda_oe_o,
    input logic wr_stb_o,
    input logic commit_o,
    input logic busy_o
);

    localparam int CW = $clog2(WR_CYCLES + 2) + 1;

    logic [CW-1:0] busy_len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_len_q <= '0;
        end else if (busy_o) begin
            busy_len_q <= busy_len_q + CW'(1);
        end else begin
            busy_len_q <= '0;
        end
    end

    assert_quiet_when_busy_R9: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (!sda_oe_o && !wr_stb_o));

    assert_ack_with_byte_R5: assert property (@(posedge clk) disable iff (rst)
        wr_stb_o |-> sda_oe_o);

    assert_ack_starts_scl_low_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe_o) |-> !scl_i);

    assert_commit_sets_busy_R7: assert property (@(posedge clk) disable iff (rst)
        commit_o |=> busy_o);

    assert_commit_not_busy_R9: assert property (@(posedge clk) disable iff (rst)
        commit_o |-> !busy_o);

    assert_busy_len_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (busy_len_q == CW'(WR_CYCLES)));

    assert_busy_bounded_R7: assert property (@(posedge clk) disable iff (rst)
        busy_len_q <= CW'(WR_CYCLES));

endmodule

bind i2c_eewr_slave eewr_checker #(.WR_CYCLES(WR_CYCLES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_oe_o (sda_oe_o),
    .wr_stb_o (wr_stb_o),
    .commit_o (commit_o),
    .busy_o   (busy_o)
);

// File: tb/sim_i2c_eewr_slave.sv
`timescale 1ns/1ps
module sim_i2c_eewr_slave;

    localparam int WRC = 300;
    localparam int Q   = 6;
    localparam int H   = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_line;
    logic        sda_oe;
    logic        wr_stb;
    logic [16:0] wr_addr;
    logic [7:0]  wr_data;
    logic        commit;
    logic        busy;

    int tests = 0;
    int fails = 0;

    logic [16:0] log_addr [0:511];
    logic [7:0]  log_data [0:511];
    int          n_stb = 0;
    int          n_commit = 0;
    int          busy_run = 0;
    int          last_busy_len = 0;
    logic [7:0]  wdata [0:255];

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_eewr_slave #(.WR_CYCLES(WRC)) u0 (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe_o  (sda_oe),
        .wr_stb_o  (wr_stb),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data),
        .commit_o  (commit),
        .busy_o    (busy)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (wr_stb && n_stb < 512) begin
                log_addr[n_stb] = wr_addr;
                log_data[n_stb] = wr_data;
                n_stb++;
            end
            if (commit) n_commit++;
            if (busy) busy_run++;
            else if (busy_run != 0) begin
                last_busy_len = busy_run;
                busy_run = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [16:0] exp_addr(input logic [16:0] a, input int k);
        logic [6:0] lo;
        lo = 7'(int'(a[6:0]) + k);
        return {a[16:7], lo};
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(Q);
        scl_m = 1'b1; wait_clk(H);
        sda_m = 1'b0; wait_clk(H);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b1; wait_clk(H);
        sda_m = 1'b1; wait_clk(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_clk(Q);
            scl_m = 1'b1; wait_clk(H);
            scl_m = 1'b0; wait_clk(Q);
        end
        sda_m = 1'b1; wait_clk(Q);
        scl_m = 1'b1; wait_clk(H/2);
        acked = ~sda_line;
        wait_clk(H/2);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    function automatic logic [7:0] sel_byte(input logic [16:0] a);
        return {4'b1010, 2'b00, a[16], 1'b0};
    endfunction

    task automatic write_txn(input logic [16:0] a, input int n, input bit do_stop,
                             input string tag);
        bit ack;
        bus_start();
        send_byte(sel_byte(a), ack);
        chk(ack, {tag, " R2 select ack"}, ack, 1);
        send_byte(a[15:8], ack);
        chk(ack, {tag, " R4 addr hi ack"}, ack, 1);
        send_byte(a[7:0], ack);
        chk(ack, {tag, " R4 addr lo ack"}, ack, 1);
        for (int k = 0; k < n; k++) begin
            send_byte(wdata[k % 256], ack);
            if (!ack) chk(1'b0, {tag, " R5 data ack"}, k, 1);
        end
        if (do_stop) bus_stop();
    endtask

    task automatic verify_log(input int base, input logic [16:0] a, input int n,
                              input string tag);
        int bad;
        bad = 0;
        chk(n_stb == base + n, {tag, " R5 strobe count"}, n_stb - base, n);
        for (int k = 0; k < n && base + k < n_stb; k++) begin
            if (log_addr[base+k] != exp_addr(a, k)) begin
                if (bad == 0)
                    chk(1'b0, {tag, " R6 address"}, int'(log_addr[base+k]),
                        int'(exp_addr(a, k)));
                bad++;
            end
            if (log_data[base+k] != wdata[k % 256]) begin
                if (bad == 0)
                    chk(1'b0, {tag, " R5 data"}, int'(log_data[base+k]),
                        int'(wdata[k % 256]));
                bad++;
            end
        end
        chk(bad == 0, {tag, " R5 R6 stream"}, bad, 0);
    endtask

    task automatic wait_not_busy();
        while (busy) @(negedge clk);
        wait_clk(20);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    initial begin
        bit ack;
        int base, c0;
        logic [16:0] a;
        int n;
        void'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) wdata[i] = 8'($urandom);

        wait_clk(5);
        chk(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);
        chk(busy == 1'b0, "R1 reset busy", busy, 0);
        rst = 1'b0;
        wait_clk(20);
        chk(n_stb == 0 && n_commit == 0, "R1 no pulses after reset", n_stb + n_commit, 0);

        // single byte write, then R9: select during busy
        base = n_stb; c0 = n_commit;
        write_txn(17'h1_2345, 1, 1'b1, "byte");
        wait_clk(4);
        chk(n_commit == c0 + 1, "R7 commit once", n_commit - c0, 1);
        chk(busy == 1'b1, "R7 busy after commit", busy, 1);
        verify_log(base, 17'h1_2345, 1, "byte");
        bus_start();
        send_byte(sel_byte(17'h0_0000), ack);
        chk(!ack, "R9 select ignored while busy", ack, 0);
        send_byte(8'h00, ack);
        chk(!ack, "R9 byte ignored while busy", ack, 0);
        bus_stop();
        chk(n_stb == base + 1, "R9 no strobe while busy", n_stb - base, 1);
        wait_not_busy();
        chk(last_busy_len == WRC, "R7 busy length", last_busy_len, WRC);
        chk(n_commit == c0 + 1, "R9 no commit while busy", n_commit - c0, 1);

        // R3 bad type code
        base = n_stb;
        bus_start();
        send_byte(8'b1011_0000, ack);
        chk(!ack, "R3 bad type nack", ack, 0);
        send_byte(8'h12, ack);
        chk(!ack, "R3 stays silent", ack, 0);
        send_byte(8'h34, ack);
        send_byte(8'h56, ack);
        chk(!ack, "R3 data silent", ack, 0);
        bus_stop();
        // R3 read request
        bus_start();
        send_byte(8'b1010_0001, ack);
        chk(!ack, "R3 read nack", ack, 0);
        bus_stop();
        wait_clk(10);
        chk(n_stb == base, "R3 no strobes", n_stb - base, 0);

        // R8 stop without data
        c0 = n_commit;
        write_txn(17'h0_1111, 0, 1'b1, "nodata");
        wait_clk(10);
        chk(n_commit == c0, "R8 no commit", n_commit - c0, 0);
        chk(busy == 1'b0, "R8 not busy", busy, 0);

        // R6 page wrap: offset 126, 130 bytes
        base = n_stb; c0 = n_commit;
        write_txn(17'h0_357E, 130, 1'b1, "wrap");
        wait_clk(4);
        verify_log(base, 17'h0_357E, 130, "wrap");
        chk(log_addr[base+2] == 17'h0_3500, "R6 wrap to page start",
            int'(log_addr[base+2]), 'h3500);
        chk(log_addr[base+128] == 17'h0_357E, "R6 129th reuses first",
            int'(log_addr[base+128]), 'h357E);
        chk(n_commit == c0 + 1, "R7 commit after burst", n_commit - c0, 1);
        wait_not_busy();

        // R10 repeated start mid transaction
        base = n_stb; c0 = n_commit;
        write_txn(17'h1_0F00, 2, 1'b0, "abort");
        write_txn(17'h0_00A0, 1, 1'b1, "restart");
        wait_clk(4);
        chk(n_commit == c0 + 1, "R10 single commit", n_commit - c0, 1);
        chk(n_stb == base + 3, "R10 strobes", n_stb - base, 3);
        chk(log_addr[base+2] == 17'h0_00A0, "R10 new address", int'(log_addr[base+2]), 'hA0);
        chk(log_data[base+2] == wdata[0], "R10 new data", int'(log_data[base+2]), int'(wdata[0]));
        wait_not_busy();

        // random transactions
        for (int t = 0; t < 8; t++) begin
            a = 17'($urandom);
            n = 1 + int'($urandom % 6);
            for (int i = 0; i < n; i++) wdata[i] = 8'($urandom);
            base = n_stb; c0 = n_commit;
            write_txn(a, n, 1'b1, "rand");
            wait_clk(4);
            verify_log(base, a, n, "rand");
            chk(n_commit == c0 + 1, "R7 rand commit", n_commit - c0, 1);
            wait_not_busy();
            chk(last_busy_len == WRC, "R7 rand busy length", last_busy_len, WRC);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule